// File: doc/BRIEF.md
# Four-Way Write-Back Cache Controller with Address-Matched Line Purge

This block holds the tags, state bits, replacement order and data storage of a 4-kbyte cache. The cache has four ways, 64 sets and 16-byte lines. A CPU-side request/ready port carries byte, word and longword accesses, and the top three address bits pick what an access means. Ordinary accesses look up the cache. A miss fetches a whole line through a line-wide memory handshake port. If the line being replaced is dirty, it is first written back through the same port. Because of that write-back, software can flush the cache by reading a different 4-kbyte area in 16-byte steps.

One address window turns an access into an invalidate command. The block takes the tag and set from the address, compares the tag against all four ways of that set, and clears the valid bit of the way that matches. A dirty line is discarded, not saved. A second window reads or writes the data storage directly, by way, set and byte, and does not use the memory port.

Top module: `wb_cache_ctrl`

## Requirements
- R1: After reset the ready, error and memory request outputs are low. Every line is invalid, and the replacement order has way 0 as least recently used.
- R2: Address bits 31:29 select the access kind. 3'b010 is an invalidate command and 3'b011 is a direct storage access. Every other value is a cacheable access, with tag in bits 28:10, set in bits 9:4 and byte offset in bits 3:0.
- R3: A cacheable read that hits sets ready in its second cycle. Read data is the 32-bit word at offset bits 3:2, where byte k of a line sits at line bits 8k+7:8k. A hit makes no memory request.
- R4: A cacheable miss issues one line fill (mem_we low) to the line-aligned address. It writes the returned 128-bit line into the victim way, then completes as a hit.
- R5: When the victim is valid and dirty, its line is written back (mem_we high) at its own line address before the fill. A clean victim causes no write-back.
- R6: The victim is the least recently used way of the set. A hit or a fill makes that way most recently used.
- R7: Write data sits on byte lanes of req_wdata that match the address. Size encoding is 0 byte, 1 word (16-bit aligned) and 2 longword (32-bit aligned). A cacheable write updates only the addressed bytes and marks the line dirty.
- R8: An invalidate command may be a read or a write and has the same effect either way. It sets ready in its second cycle and clears the valid bit of the way whose valid tag matches bits 28:10 in set bits 9:4. Bits 3:0 are ignored.
- R9: A dirty line that is invalidated is never written back. A later miss that fetches the same address returns memory contents.
- R10: An invalidate command that matches no way still takes two cycles and changes nothing. An invalidate command that hits does not change the replacement order.
- R11: An invalidate command that is not longword-sized changes nothing. It raises purge_err for one cycle, together with ready.
- R12: A direct access uses bits 11:10 as way, 9:4 as set and 3:0 as byte. A read sets ready in its first cycle and a write in its second. The R7 lane rules apply, and the memory port is not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present, held stable until ready |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 0 byte, 1 word, 2 longword |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data on address-matched lanes |
| req_ready | output | 1 | Request completes this cycle |
| req_rdata | output | 32 | Word containing the addressed byte |
| purge_err | output | 1 | Non-longword invalidate command rejected |
| mem_req | output | 1 | Memory transfer requested, held until ack |
| mem_we | output | 1 | 1 for write-back, 0 for fill |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wline | output | 128 | Write-back line data |
| mem_rline | input | 128 | Fill line data, valid with ack |
| mem_ack | input | 1 | Memory transfer done this cycle |

## Verification
The critical overlap is an invalidate command landing on a line that holds dirty data. The clear of the valid bit must win over the write-back that a later replacement of that line would otherwise trigger. The bench dirties a line, invalidates it, and then reads the same address again. It judges the outcome from the write-back counter, which must not move, and from the refilled word, which must equal the memory pattern and not the stale written value. A second overlap is a fill and the replacement-order update landing on the same edge. The bench checks this by running a chain of misses and hits on one set and reading back, through the direct window, which way each line landed in.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int OFF_W      = 4;
  localparam int LINE_BYTES = 1 << OFF_W;
  localparam int LINE_W     = 8 * LINE_BYTES;
  localparam int WORD_W     = 32;
  localparam int WORDS      = LINE_W / WORD_W;
  localparam logic [2:0] RGN_PURGE  = 3'b010;
  localparam logic [2:0] RGN_DIRECT = 3'b011;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2} acc_size_e;

  // Byte enables within a line for an access of a given size and offset.
  function automatic logic [LINE_BYTES-1:0] lane_mask(input logic [1:0] sz,
                                                      input logic [OFF_W-1:0] off);
    logic [LINE_BYTES-1:0] m;
    case (sz)
      SZ_BYTE: m = LINE_BYTES'(1) << off;
      SZ_WORD: m = LINE_BYTES'(3) << {off[OFF_W-1:1], 1'b0};
      SZ_LONG: m = LINE_BYTES'(15) << {off[OFF_W-1:2], 2'b00};
      default: m = '0;
    endcase
    return m;
  endfunction

  // Word of a line that contains the addressed byte.
  function automatic logic [WORD_W-1:0] word_pick(input logic [LINE_W-1:0] line,
                                                  input logic [OFF_W-1:0] off);
    return line[{off[OFF_W-1:2], 5'b00000} +: WORD_W];
  endfunction
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int TAG_W = 19,
  parameter int IDX_W = 6,
  parameter int WAYS  = 4,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            lk_idx,
  input  logic [TAG_W-1:0]            lk_tag,
  output logic [WAYS-1:0]             hit_vec,
  output logic [WAYS-1:0]             valid_vec,
  output logic [WAYS-1:0]             dirty_vec,
  output logic [WAYS-1:0][TAG_W-1:0]  tag_rd,
  input  logic                        fill_en,
  input  logic [WAY_W-1:0]            fill_way,
  input  logic                        dirty_en,
  input  logic [WAY_W-1:0]            dirty_way,
  input  logic                        clr_en,
  input  logic [WAY_W-1:0]            clr_way
);
  logic [WAYS-1:0]  valid_q [ENTRIES];
  logic [WAYS-1:0]  dirty_q [ENTRIES];
  logic [TAG_W-1:0] tag_q   [ENTRIES][WAYS];

  assign valid_vec = valid_q[lk_idx];
  assign dirty_vec = dirty_q[lk_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign tag_rd[w]  = tag_q[lk_idx][w];
    assign hit_vec[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        valid_q[e] <= '0;
        dirty_q[e] <= '0;
      end
    end else begin
      if (fill_en) begin
        valid_q[lk_idx][fill_way] <= 1'b1;
        dirty_q[lk_idx][fill_way] <= 1'b0;
      end
      if (dirty_en) dirty_q[lk_idx][dirty_way] <= 1'b1;
      if (clr_en) begin
        valid_q[lk_idx][clr_way] <= 1'b0;
        dirty_q[lk_idx][clr_way] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[lk_idx][fill_way] <= lk_tag;
  end

  // R2
  hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
  // R8
  purge_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !valid_q[$past(lk_idx)][$past(clr_way)]);
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int IDX_W = 6,
  parameter int WAYS  = 4,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim_way
);
  // Rank 0 is least recently used, WAYS-1 most recently used.
  logic [WAY_W-1:0] rank_q [ENTRIES][WAYS];

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (rank_q[idx][w] == '0) victim_way = WAY_W'(w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++)
        for (int w = 0; w < WAYS; w++)
          rank_q[e][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          rank_q[idx][w] <= WAY_W'(WAYS - 1);
        else if (rank_q[idx][w] > rank_q[idx][touch_way])
          rank_q[idx][w] <= rank_q[idx][w] - 1'b1;
      end
    end
  end

  // R6
  touch_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> rank_q[$past(idx)][$past(touch_way)] == WAY_W'(WAYS - 1));
endmodule

// File: rtl/cache_data_array.sv
module cache_data_array #(
  parameter int IDX_W  = 6,
  parameter int WAYS   = 4,
  parameter int LINE_W = 128,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int ENTRIES = 1 << IDX_W,
  localparam int NBYTES  = LINE_W / 8
) (
  input  logic              clk,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [NBYTES-1:0] wr_mask
);
  logic [LINE_W-1:0] line_q [WAYS*ENTRIES];

  assign rd_line = line_q[{rd_way, rd_idx}];

  always_ff @(posedge clk) begin
    if (wr_en)
      for (int b = 0; b < NBYTES; b++)
        if (wr_mask[b]) line_q[{wr_way, wr_idx}][8*b +: 8] <= wr_line[8*b +: 8];
  end
endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
  import cache_pkg::*;
#(
  parameter int TAG_W = 19,
  parameter int IDX_W = 6,
  parameter int WAYS  = 4,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int ADDR_W = 3 + TAG_W + IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [WORD_W-1:0] req_rdata,
  output logic              purge_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wline,
  input  logic [LINE_W-1:0] mem_rline,
  input  logic              mem_ack
);
  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_WB, S_FILL, S_PURGE, S_DWR} state_e;
  state_e state_q, state_d;

  // Address fields
  logic [2:0]       region;
  logic [TAG_W-1:0] a_tag;
  logic [IDX_W-1:0] a_idx;
  logic [OFF_W-1:0] a_off;
  logic [WAY_W-1:0] a_way;
  logic             is_purge, is_direct;
  assign region    = req_addr[ADDR_W-1 -: 3];
  assign a_tag     = req_addr[OFF_W+IDX_W +: TAG_W];
  assign a_idx     = req_addr[OFF_W +: IDX_W];
  assign a_off     = req_addr[OFF_W-1:0];
  assign a_way     = req_addr[OFF_W+IDX_W +: WAY_W];
  assign is_purge  = (region == RGN_PURGE);
  assign is_direct = (region == RGN_DIRECT);

  // Lookup
  logic [WAYS-1:0]            hit_vec, valid_vec, dirty_vec;
  logic [WAYS-1:0][TAG_W-1:0] tag_rd;
  logic                       hit;
  logic [WAY_W-1:0]           hit_way, lru_victim, victim_q;
  assign hit = |hit_vec;
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  // Named internal events
  logic idle_take, look_hit, look_miss, fill_done, wb_done, purge_do, purge_hit, purge_bad;
  assign idle_take = (state_q == S_IDLE) && req_valid;
  assign look_hit  = (state_q == S_LOOK) && hit;
  assign look_miss = (state_q == S_LOOK) && !hit;
  assign fill_done = (state_q == S_FILL) && mem_ack;
  assign wb_done   = (state_q == S_WB) && mem_ack;
  assign purge_do  = (state_q == S_PURGE);
  assign purge_bad = purge_do && (req_size != SZ_LONG);
  assign purge_hit = purge_do && !purge_bad && hit;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (req_valid) begin
        if (is_purge)       state_d = S_PURGE;
        else if (is_direct) state_d = req_write ? S_DWR : S_IDLE;
        else                state_d = S_LOOK;
      end
      S_LOOK: if (hit) state_d = S_IDLE;
              else if (valid_vec[lru_victim] && dirty_vec[lru_victim]) state_d = S_WB;
              else state_d = S_FILL;
      S_WB:    if (mem_ack) state_d = S_FILL;
      S_FILL:  if (mem_ack) state_d = S_LOOK;
      S_PURGE: state_d = S_IDLE;
      S_DWR:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      victim_q <= '0;
    end else begin
      state_q <= state_d;
      if (look_miss) victim_q <= lru_victim;
    end
  end

  cache_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WAYS(WAYS)) u_tags (
    .clk(clk), .rst_n(rst_n), .lk_idx(a_idx), .lk_tag(a_tag),
    .hit_vec(hit_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec), .tag_rd(tag_rd),
    .fill_en(fill_done), .fill_way(victim_q),
    .dirty_en(look_hit && req_write), .dirty_way(hit_way),
    .clr_en(purge_hit), .clr_way(hit_way)
  );

  cache_lru #(.IDX_W(IDX_W), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n), .idx(a_idx),
    .touch_en(look_hit || fill_done),
    .touch_way(fill_done ? victim_q : hit_way),
    .victim_way(lru_victim)
  );

  // Data array ports
  logic [WAY_W-1:0]      rd_way, wr_way;
  logic [LINE_W-1:0]     rd_line, wr_line;
  logic [LINE_BYTES-1:0] wr_mask;
  logic                  wr_en;

  always_comb begin
    if (state_q == S_IDLE)    rd_way = a_way;
    else if (state_q == S_WB) rd_way = victim_q;
    else                      rd_way = hit_way;
  end

  assign wr_en   = fill_done || (look_hit && req_write) || (state_q == S_DWR);
  assign wr_way  = fill_done ? victim_q : ((state_q == S_DWR) ? a_way : hit_way);
  assign wr_line = fill_done ? mem_rline : {WORDS{req_wdata}};
  assign wr_mask = fill_done ? '1 : lane_mask(req_size, a_off);

  cache_data_array #(.IDX_W(IDX_W), .WAYS(WAYS), .LINE_W(LINE_W)) u_data (
    .clk(clk), .rd_way(rd_way), .rd_idx(a_idx), .rd_line(rd_line),
    .wr_en(wr_en), .wr_way(wr_way), .wr_idx(a_idx), .wr_line(wr_line), .wr_mask(wr_mask)
  );

  // Outputs
  assign req_ready = look_hit || purge_do || (state_q == S_DWR) ||
                     (idle_take && is_direct && !req_write);
  assign req_rdata = word_pick(rd_line, a_off);
  assign purge_err = purge_bad;
  assign mem_req   = (state_q == S_WB) || (state_q == S_FILL);
  assign mem_we    = (state_q == S_WB);
  assign mem_addr  = (state_q == S_WB) ? {3'b000, tag_rd[victim_q], a_idx, {OFF_W{1'b0}}}
                                       : {3'b000, a_tag, a_idx, {OFF_W{1'b0}}};
  assign mem_wline = rd_line;

  // R8
  purge_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_take && is_purge) |=> (req_ready && !mem_req));
  // R11
  purge_err_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    purge_err |-> (req_ready && req_size != SZ_LONG));
  // R12
  direct_read_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_take && is_direct && !req_write) |-> (req_ready && !mem_req));
  // R5
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> (mem_req && !mem_we));
  // R4
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> look_hit);
endmodule

// File: tb/wb_cache_ctrl_tb.sv
module wb_cache_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic req_ready, purge_err, mem_req, mem_we;
  logic [31:0] req_rdata, mem_addr;
  logic [127:0] mem_wline, mem_rline = '0;
  logic mem_ack = 0;

  wb_cache_ctrl u_dut (.*);

  int checks = 0, errors = 0;
  int fills = 0, wbs = 0;
  logic [7:0] op_log = 0;
  logic [31:0] wb_addr;
  logic [127:0] wb_line;

  function automatic logic [31:0] fw(input logic [31:0] a, input int j);
    return ({a[31:4], 4'b0} + 32'(j * 4)) ^ 32'h3C3C_0000;
  endfunction
  function automatic logic [31:0] ca(input logic [18:0] t, input logic [5:0] i, input logic [3:0] o);
    return {3'b000, t, i, o};
  endfunction
  function automatic logic [31:0] pa(input logic [18:0] t, input logic [5:0] i, input logic [3:0] o);
    return {3'b010, t, i, o};
  endfunction
  function automatic logic [31:0] da(input logic [1:0] w, input logic [5:0] i, input logic [3:0] o);
    return {3'b011, 17'b0, w, i, o};
  endfunction

  // Memory model
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      mem_ack = 1;
      op_log = {op_log[6:0], mem_we};
      if (mem_we) begin
        wbs++; wb_addr = mem_addr; wb_line = mem_wline;
      end else begin
        fills++;
        for (int j = 0; j < 4; j++) mem_rline[32*j +: 32] = fw(mem_addr, j);
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output int cyc, output bit err);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    cyc = 0;
    forever begin
      #1; cyc++;
      if (req_ready) begin rd = req_rdata; err = purge_err; break; end
      @(negedge clk);
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  logic [31:0] rd; int cyc; bit err; int f0, w0;

  task automatic t_reset();
    #1;
    chk(!req_ready && !purge_err && !mem_req, "R1 reset outputs", {req_ready, purge_err, mem_req}, 0);
  endtask

  task automatic t_miss_hit();
    f0 = fills;
    acc(0, 2, ca(19'h111, 6'd3, 4'h4), 0, rd, cyc, err);
    chk(rd == fw(ca(19'h111, 6'd3, 0), 1), "R4 fill data", rd, fw(ca(19'h111, 6'd3, 0), 1));
    chk(fills == f0 + 1, "R4 one fill", fills, f0 + 1);
    acc(0, 2, ca(19'h111, 6'd3, 4'hC), 0, rd, cyc, err);
    chk(cyc == 2 && fills == f0 + 1, "R3 hit latency", cyc, 2);
    chk(rd == fw(ca(19'h111, 6'd3, 0), 3), "R3 hit word", rd, fw(ca(19'h111, 6'd3, 0), 3));
    acc(0, 2, {3'b001, 19'h111, 6'd3, 4'h0}, 0, rd, cyc, err);
    chk(cyc == 2, "R2 alias region cacheable", cyc, 2);
  endtask

  task automatic t_lru();
    for (int k = 0; k < 4; k++) acc(0, 2, ca(19'h200 + 19'(k), 6'd5, 0), 0, rd, cyc, err);
    for (int k = 0; k < 4; k++) begin
      acc(0, 2, da(2'(k), 6'd5, 0), 0, rd, cyc, err);
      chk(rd == fw(ca(19'h200 + 19'(k), 6'd5, 0), 0), "R1 R6 way order after reset", rd,
          fw(ca(19'h200 + 19'(k), 6'd5, 0), 0));
    end
    acc(0, 2, ca(19'h200, 6'd5, 0), 0, rd, cyc, err);
    w0 = wbs;
    acc(0, 2, ca(19'h2FF, 6'd5, 0), 0, rd, cyc, err);
    acc(0, 2, da(2'd1, 6'd5, 0), 0, rd, cyc, err);
    chk(rd == fw(ca(19'h2FF, 6'd5, 0), 0), "R6 lru victim way1", rd, fw(ca(19'h2FF, 6'd5, 0), 0));
    chk(wbs == w0, "R5 clean victim no writeback", wbs, w0);
    f0 = fills;
    acc(0, 2, ca(19'h200, 6'd5, 0), 0, rd, cyc, err);
    chk(fills == f0 && cyc == 2, "R6 touched way kept", fills, f0);
  endtask

  task automatic t_write_evict();
    logic [127:0] exp;
    acc(0, 2, ca(19'h300, 6'd9, 0), 0, rd, cyc, err);
    acc(1, 2, ca(19'h300, 6'd9, 4'h8), 32'h1122_3344, rd, cyc, err);
    acc(1, 0, ca(19'h300, 6'd9, 4'h1), 32'h0000_AB00, rd, cyc, err);
    acc(1, 1, ca(19'h300, 6'd9, 4'hE), 32'hBEEF_0000, rd, cyc, err);
    exp[31:0]   = (fw(ca(19'h300, 6'd9, 0), 0) & 32'hFFFF_00FF) | 32'h0000_AB00;
    exp[63:32]  = fw(ca(19'h300, 6'd9, 0), 1);
    exp[95:64]  = 32'h1122_3344;
    exp[127:96] = (fw(ca(19'h300, 6'd9, 0), 3) & 32'h0000_FFFF) | 32'hBEEF_0000;
    acc(0, 2, ca(19'h300, 6'd9, 4'h0), 0, rd, cyc, err);
    chk(rd == exp[31:0], "R7 byte merge", rd, exp[31:0]);
    acc(0, 2, ca(19'h300, 6'd9, 4'hC), 0, rd, cyc, err);
    chk(rd == exp[127:96], "R7 word merge", rd, exp[127:96]);
    for (int k = 1; k < 4; k++) acc(0, 2, ca(19'h300 + 19'(k), 6'd9, 0), 0, rd, cyc, err);
    w0 = wbs;
    acc(0, 2, ca(19'h3FF, 6'd9, 0), 0, rd, cyc, err);
    chk(wbs == w0 + 1 && op_log[1:0] == 2'b10, "R5 writeback before fill", op_log[1:0], 2'b10);
    chk(wb_addr == ca(19'h300, 6'd9, 0), "R5 writeback address", wb_addr, ca(19'h300, 6'd9, 0));
    chk(wb_line == exp, "R5 R7 writeback line", wb_line, exp);
  endtask

  task automatic t_purge();
    acc(0, 2, ca(19'h400, 6'd12, 0), 0, rd, cyc, err);
    acc(1, 2, ca(19'h400, 6'd12, 0), 32'hDEAD_DEAD, rd, cyc, err);
    acc(1, 2, pa(19'h400, 6'd12, 4'hC), 0, rd, cyc, err);
    chk(cyc == 2 && !err, "R8 purge write two cycles", cyc, 2);
    w0 = wbs; f0 = fills;
    acc(0, 2, ca(19'h400, 6'd12, 0), 0, rd, cyc, err);
    chk(fills == f0 + 1 && wbs == w0, "R9 dirty purged no writeback", wbs, w0);
    chk(rd == fw(ca(19'h400, 6'd12, 0), 0), "R9 refetch memory data", rd, fw(ca(19'h400, 6'd12, 0), 0));
    // purge miss, then purge by read
    acc(0, 2, ca(19'h500, 6'd13, 0), 0, rd, cyc, err);
    acc(0, 2, pa(19'h5AA, 6'd13, 0), 0, rd, cyc, err);
    chk(cyc == 2 && !err, "R10 purge miss two cycles", cyc, 2);
    f0 = fills;
    acc(0, 2, ca(19'h500, 6'd13, 0), 0, rd, cyc, err);
    chk(fills == f0, "R10 purge miss no change", fills, f0);
    acc(0, 2, pa(19'h500, 6'd13, 4'h7), 0, rd, cyc, err);
    acc(0, 2, ca(19'h500, 6'd13, 0), 0, rd, cyc, err);
    chk(fills == f0 + 1, "R8 purge by read invalidates", fills, f0 + 1);
  endtask

  task automatic t_purge_lru();
    for (int k = 0; k < 4; k++) acc(0, 2, ca(19'h600 + 19'(k), 6'd15, 0), 0, rd, cyc, err);
    acc(1, 2, pa(19'h600, 6'd15, 0), 0, rd, cyc, err);
    acc(0, 2, ca(19'h6FF, 6'd15, 0), 0, rd, cyc, err);
    acc(0, 2, da(2'd0, 6'd15, 0), 0, rd, cyc, err);
    chk(rd == fw(ca(19'h6FF, 6'd15, 0), 0), "R10 purge hit keeps lru order", rd, fw(ca(19'h6FF, 6'd15, 0), 0));
  endtask

  task automatic t_purge_bad();
    acc(0, 2, ca(19'h700, 6'd14, 0), 0, rd, cyc, err);
    acc(1, 1, pa(19'h700, 6'd14, 0), 0, rd, cyc, err);
    chk(cyc == 2 && err, "R11 short purge flags error", err, 1);
    f0 = fills;
    acc(0, 2, ca(19'h700, 6'd14, 0), 0, rd, cyc, err);
    chk(fills == f0 && !err, "R11 short purge ignored", fills, f0);
  endtask

  task automatic t_direct();
    f0 = fills + wbs;
    acc(1, 2, da(2'd2, 6'd20, 4'h8), 32'hCAFE_F00D, rd, cyc, err);
    chk(cyc == 2, "R12 direct write two cycles", cyc, 2);
    acc(0, 2, da(2'd2, 6'd20, 4'h8), 0, rd, cyc, err);
    chk(cyc == 1 && rd == 32'hCAFE_F00D, "R12 direct read one cycle", rd, 32'hCAFE_F00D);
    acc(1, 0, da(2'd2, 6'd20, 4'h9), 32'h0000_7700, rd, cyc, err);
    acc(1, 1, da(2'd2, 6'd20, 4'hA), 32'h1234_0000, rd, cyc, err);
    acc(0, 0, da(2'd2, 6'd20, 4'hB), 0, rd, cyc, err);
    chk(rd == 32'h1234_770D, "R12 R7 direct byte and word lanes", rd, 32'h1234_770D);
    chk(fills + wbs == f0, "R12 no memory traffic", fills + wbs, f0);
  endtask

  initial begin
    #20000000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_miss_hit();
    t_lru();
    t_write_evict();
    t_purge();
    t_purge_lru();
    t_purge_bad();
    t_direct();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule